// File: doc/BRIEF.md
# Speculative Block Read/Write Tracker

This unit sits beside one processor and lets a code block execute ahead of its turn. While a speculative block is open, every word the processor fetches from memory is recorded in a small read-set store and marked as a dependency. Every word it writes goes into a private write buffer, so no other processor can see it. A processor read checks the write buffer first, then the read-set store, and only then goes to memory. The block therefore always sees its own writes.

A snoop port observes the bus writes made by whichever other block is committing at the time. If such a write lands on a word in the read-set store, this block consumed that value too early. The unit then reports a violation and discards everything the block has done. The processor side may also abort the block explicitly. Commit happens only when the processor requests it and an external in-order grant is asserted in the same cycle. The write buffer is then drained to a memory write port one entry per cycle, and a done pulse closes the block.

Top module: `spec_rw_tracker`

## Requirements
- R1: With no speculative block open, `reqReady` stays low whatever `reqValid` does and `memRdReq` stays low. A `ctlStart` pulse opens a block, and `specActive` is high while a block is open or committing.
- R2: A read that misses both structures raises `memRdReq` with the read address on `memRdAddr`. The cycle after the clock edge that samples `memRdAck`, `rspValid` is high and `rspData` carries `memRdData`. That word is recorded as a dependency.
- R3: A read of a word already recorded as a dependency is answered from the read-set store without a memory read. `rspValid` is high in the cycle after the edge that accepts the request.
- R4: Writes made during a block are held in the write buffer. `memWrValid` stays low until a commit is accepted.
- R5: A read of an address present in the write buffer returns the latest buffered data, ahead of any dependency copy. A second write to a buffered address overwrites that entry and takes no new slot.
- R6: When `snoopValid` is high with `snoopAddr` equal to a recorded dependency while a block is open, `violation` is high for exactly one cycle, following that edge. At the same edge the block is aborted: both structures are emptied, nothing is written back and `specActive` drops.
- R7: A snooped write to an address held only in the write buffer, or to an untracked address, causes no violation and leaves the block open.
- R8: `ctlAbort` empties both structures at one edge with no memory write. A read waiting on memory is dropped without any response. A read made in the next block goes to memory again.
- R9: A commit is accepted only at an edge where `ctlCommit` and `commitGrant` are both high. `ctlCommit` alone leaves the block open and still accepting requests.
- R10: The drain presents buffered writes in the order in which their addresses were first written in the block. It moves to the next entry only at an edge where `memWrValid` and `memWrReady` are both high.
- R11: With the default 8 slots, a write to a new address with the write buffer full stalls (`reqReady` low). So does a memory-bound read with the read-set store full. Writes to buffered addresses and reads that hit are still accepted.
- R12: `commitDone` is a one-cycle pulse. With K buffered entries and `memWrReady` held high, it is high in the cycle that follows the (K+1)-th clock edge after the edge that accepts the commit. Afterwards the unit is idle with both structures empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlStart | input | 1 | Opens a speculative block when idle |
| ctlCommit | input | 1 | Requests commit of the open block |
| commitGrant | input | 1 | In-order permission to commit |
| ctlAbort | input | 1 | Discards the open block |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request word address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted at this edge |
| rspValid | output | 1 | Read response valid |
| rspData | output | DATA_W | Read response data |
| snoopValid | input | 1 | Bus write by a committing block observed |
| snoopAddr | input | ADDR_W | Address of the snooped write |
| memRdReq | output | 1 | Memory read request, held until acknowledged |
| memRdAddr | output | ADDR_W | Memory read address |
| memRdAck | input | 1 | Memory read data valid |
| memRdData | input | DATA_W | Memory read data |
| memWrValid | output | 1 | Drained write valid |
| memWrReady | input | 1 | Memory accepts the drained write |
| memWrAddr | output | ADDR_W | Drained write address |
| memWrData | output | DATA_W | Drained write data |
| violation | output | 1 | One-cycle dependency-violation pulse |
| commitDone | output | 1 | One-cycle pulse after the drain completes |
| specActive | output | 1 | A block is open or committing |

## Verification
The read path is driven with a cold miss, a repeated read, a read after the block's own write and a read after a rewrite. These separate a memory fetch, a read-set hit, write-buffer priority and write coalescing, using a count of memory reads and the returned data. Snoops aim at a dependency word, at a word held only in the write buffer and at an untracked address, which tells a real conflict from a harmless one. Commit is tried without the grant, with an empty buffer, with three entries under constant readiness (to time the done pulse) and with eight entries under alternating backpressure (to confirm drain order and hold). Filling both structures to capacity and then sending hits and new addresses shows that a stall applies only to requests that need a new slot.

// File: rtl/spec_track_pkg.sv
package spec_track_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_DRAIN  = 2'd3
  } specState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clearAll;    // drop every dependency and buffered write
    logic pendLoad;    // capture the address of a memory-bound read
    logic depInstall;  // record returned memory word as a dependency
    logic cfWrite;     // place request into the write buffer
    logic drainPop;    // retire the current drain entry
    logic rspFromHit;  // load response from buffer/read-set hit
    logic rspFromMem;  // load response from memory return
  } specStrobe_t;

endpackage

// File: rtl/spec_datapath.sv
module spec_datapath
  import spec_track_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEP_N  = 8,
  parameter int CF_N   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  specStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              cfHit,
  output logic              depHit,
  output logic              cfFull,
  output logic              depFull,
  output logic              snoopDepHit,
  output logic              drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  output logic [ADDR_W-1:0] pendAddr,
  output logic [DATA_W-1:0] rspData
);

  localparam int DEP_IW = (DEP_N > 1) ? $clog2(DEP_N) : 1;
  localparam int CF_IW  = (CF_N  > 1) ? $clog2(CF_N)  : 1;

  // Read-set store ("depends" entries)
  logic [DEP_N-1:0]  depValid;
  logic [ADDR_W-1:0] depAddr [DEP_N];
  logic [DATA_W-1:0] depData [DEP_N];
  // Write buffer
  logic [CF_N-1:0]   cfValid;
  logic [ADDR_W-1:0] cfAddr  [CF_N];
  logic [DATA_W-1:0] cfData  [CF_N];

  logic [DEP_N-1:0] depHitVec, depSnoopVec;
  logic [CF_N-1:0]  cfHitVec;

  genvar g;
  generate
    for (g = 0; g < DEP_N; g++) begin : gDepCmp
      assign depHitVec[g]   = depValid[g] && (depAddr[g] == reqAddr);
      assign depSnoopVec[g] = depValid[g] && (depAddr[g] == snoopAddr);
    end
    for (g = 0; g < CF_N; g++) begin : gCfCmp
      assign cfHitVec[g] = cfValid[g] && (cfAddr[g] == reqAddr);
    end
  endgenerate

  logic [DEP_IW-1:0] depHitIdx, depFreeIdx;
  logic [CF_IW-1:0]  cfHitIdx, cfFreeIdx, drainIdx, cfWrIdx;
  logic [DATA_W-1:0] rdHitData;

  always_comb begin
    depHitIdx  = '0;
    depFreeIdx = '0;
    for (int i = DEP_N - 1; i >= 0; i--) begin
      if (depHitVec[i]) depHitIdx  = DEP_IW'(i);
      if (!depValid[i]) depFreeIdx = DEP_IW'(i);
    end
  end

  always_comb begin
    cfHitIdx  = '0;
    cfFreeIdx = '0;
    drainIdx  = '0;
    for (int i = CF_N - 1; i >= 0; i--) begin
      if (cfHitVec[i]) cfHitIdx  = CF_IW'(i);
      if (!cfValid[i]) cfFreeIdx = CF_IW'(i);
      if (cfValid[i])  drainIdx  = CF_IW'(i);
    end
  end

  assign cfHit       = |cfHitVec;
  assign depHit      = |depHitVec;
  assign cfFull      = &cfValid;
  assign depFull     = &depValid;
  assign snoopDepHit = |depSnoopVec;
  assign drainValid  = |cfValid;
  assign drainAddr   = cfAddr[drainIdx];
  assign drainData   = cfData[drainIdx];
  assign cfWrIdx     = cfHit ? cfHitIdx : cfFreeIdx;
  // Buffered writes win over the dependency copy.
  assign rdHitData   = cfHit ? cfData[cfHitIdx] : depData[depHitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depValid <= '0;
    end else if (strobe.clearAll) begin
      depValid <= '0;
    end else if (strobe.depInstall) begin
      depValid[depFreeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.depInstall) begin
      depAddr[depFreeIdx] <= pendAddr;
      depData[depFreeIdx] <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfValid <= '0;
    end else if (strobe.clearAll) begin
      cfValid <= '0;
    end else if (strobe.cfWrite && !cfHit) begin
      cfValid[cfFreeIdx] <= 1'b1;
    end else if (strobe.drainPop) begin
      cfValid[drainIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.cfWrite) begin
      cfAddr[cfWrIdx] <= reqAddr;
      cfData[cfWrIdx] <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      rspData  <= '0;
    end else begin
      if (strobe.pendLoad)   pendAddr <= reqAddr;
      if (strobe.rspFromHit) rspData  <= rdHitData;
      else if (strobe.rspFromMem) rspData <= memRdData;
    end
  end

  // An address lives in at most one slot of each structure.
  assert_cf_unique_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfHitVec));
  assert_dep_unique_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(depHitVec));
  // A clear leaves both structures empty on the following cycle.
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (cfValid == '0) && (depValid == '0));

endmodule

// File: rtl/spec_control.sv
module spec_control
  import spec_track_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlStart,
  input  logic        ctlCommit,
  input  logic        commitGrant,
  input  logic        ctlAbort,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        snoopValid,
  input  logic        memRdAck,
  input  logic        memWrReady,
  input  logic        cfHit,
  input  logic        depHit,
  input  logic        cfFull,
  input  logic        depFull,
  input  logic        snoopDepHit,
  input  logic        drainValid,
  output specStrobe_t strobe,
  output logic        reqReady,
  output logic        rspValid,
  output logic        memRdReq,
  output logic        memWrValid,
  output logic        violation,
  output logic        commitDone,
  output logic        specActive
);

  specState_e stateQ, stateD;
  logic open, violHit, kill, commitGo, doneD;

  assign open     = (stateQ == ST_ACTIVE) || (stateQ == ST_RDWAIT);
  assign violHit  = open && snoopValid && snoopDepHit;
  assign kill     = open && (ctlAbort || violHit);
  assign commitGo = (stateQ == ST_ACTIVE) && ctlCommit && commitGrant && !kill;

  assign memRdReq   = (stateQ == ST_RDWAIT);
  assign memWrValid = (stateQ == ST_DRAIN) && drainValid;
  assign specActive = (stateQ != ST_IDLE);

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    reqReady = 1'b0;
    doneD    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (ctlStart) stateD = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (kill) begin
          strobe.clearAll = 1'b1;
          stateD          = ST_IDLE;
        end else if (commitGo) begin
          stateD = ST_DRAIN;
        end else if (reqValid) begin
          if (reqWrite) begin
            if (cfHit || !cfFull) begin
              reqReady       = 1'b1;
              strobe.cfWrite = 1'b1;
            end
          end else if (cfHit || depHit) begin
            reqReady          = 1'b1;
            strobe.rspFromHit = 1'b1;
          end else if (!depFull) begin
            reqReady        = 1'b1;
            strobe.pendLoad = 1'b1;
            stateD          = ST_RDWAIT;
          end
        end
      end
      ST_RDWAIT: begin
        if (kill) begin
          strobe.clearAll = 1'b1;
          stateD          = ST_IDLE;
        end else if (memRdAck) begin
          strobe.depInstall = 1'b1;
          strobe.rspFromMem = 1'b1;
          stateD            = ST_ACTIVE;
        end
      end
      ST_DRAIN: begin
        if (drainValid) begin
          if (memWrReady) strobe.drainPop = 1'b1;
        end else begin
          strobe.clearAll = 1'b1;
          doneD           = 1'b1;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      rspValid   <= 1'b0;
      violation  <= 1'b0;
      commitDone <= 1'b0;
    end else begin
      stateQ     <= stateD;
      rspValid   <= strobe.rspFromHit || strobe.rspFromMem;
      violation  <= violHit;
      commitDone <= doneD;
    end
  end

  assert_viol_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> !violation);
  assert_viol_aborts_R6: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> !specActive && !drainValid);
  assert_commit_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DRAIN && $past(stateQ) == ST_ACTIVE) |-> $past(commitGrant && ctlCommit));
  assert_done_empty_R12: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> !drainValid && !specActive && !commitDone == 1'b0);
  assert_read_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !cfHit && !depHit && depFull) |-> !reqReady);
  assert_no_write_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    open |-> !memWrValid);

endmodule

// File: rtl/spec_rw_tracker.sv
module spec_rw_tracker
  import spec_track_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEP_N  = 8,
  parameter int CF_N   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlStart,
  input  logic              ctlCommit,
  input  logic              commitGrant,
  input  logic              ctlAbort,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              violation,
  output logic              commitDone,
  output logic              specActive
);

  specStrobe_t strobe;
  logic cfHit, depHit, cfFull, depFull, snoopDepHit, drainValid;

  spec_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .ctlStart    (ctlStart),
    .ctlCommit   (ctlCommit),
    .commitGrant (commitGrant),
    .ctlAbort    (ctlAbort),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .snoopValid  (snoopValid),
    .memRdAck    (memRdAck),
    .memWrReady  (memWrReady),
    .cfHit       (cfHit),
    .depHit      (depHit),
    .cfFull      (cfFull),
    .depFull     (depFull),
    .snoopDepHit (snoopDepHit),
    .drainValid  (drainValid),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .memRdReq    (memRdReq),
    .memWrValid  (memWrValid),
    .violation   (violation),
    .commitDone  (commitDone),
    .specActive  (specActive)
  );

  spec_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEP_N  (DEP_N),
    .CF_N   (CF_N)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .snoopAddr   (snoopAddr),
    .memRdData   (memRdData),
    .cfHit       (cfHit),
    .depHit      (depHit),
    .cfFull      (cfFull),
    .depFull     (depFull),
    .snoopDepHit (snoopDepHit),
    .drainValid  (drainValid),
    .drainAddr   (memWrAddr),
    .drainData   (memWrData),
    .pendAddr    (memRdAddr),
    .rspData     (rspData)
  );

endmodule

// File: tb/sim_spec_rw_tracker.sv
`timescale 1ns/1ps
module sim_spec_rw_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlStart = 0, ctlCommit = 0, commitGrant = 0, ctlAbort = 0;
  logic        reqValid = 0, reqWrite = 0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic [31:0] rspData;
  logic        snoopValid = 0;
  logic [15:0] snoopAddr = '0;
  logic        memRdReq;
  logic [15:0] memRdAddr;
  logic        memRdAck = 0;
  logic [31:0] memRdData = '0;
  logic        memWrValid;
  logic        memWrReady = 1'b1;
  logic [15:0] memWrAddr;
  logic [31:0] memWrData;
  logic        violation, commitDone, specActive;

  always #2.5 clk = ~clk;

  spec_rw_tracker u0 (
    .clk(clk), .rstN(rstN), .ctlStart(ctlStart), .ctlCommit(ctlCommit),
    .commitGrant(commitGrant), .ctlAbort(ctlAbort), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .memWrValid(memWrValid), .memWrReady(memWrReady), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .violation(violation), .commitDone(commitDone),
    .specActive(specActive)
  );

  int checks = 0;
  int failures = 0;
  int memRdCount = 0;
  int memWrCount = 0;
  int violCount = 0;
  logic wrStall = 1'b0;

  logic [31:0] expRd[$];
  string       expRdTag[$];
  logic [15:0] expWrAddr[$];
  logic [31:0] expWrData[$];

  function automatic logic [31:0] memVal(logic [15:0] a);
    return {a ^ 16'hC3C3, a};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model: acknowledges a held read two cycles later.
  initial forever begin
    @(negedge clk);
    if (memRdReq) begin
      repeat (2) @(negedge clk);
      if (memRdReq) begin
        memRdAck  = 1'b1;
        memRdData = memVal(memRdAddr);
        memRdCount++;
        @(negedge clk);
        memRdAck = 1'b0;
      end
    end
  end

  // Write-port readiness, optionally alternating.
  initial forever begin
    @(posedge clk);
    #1;
    memWrReady = wrStall ? ~memWrReady : 1'b1;
  end

  // Monitor: pops the scoreboard as results appear.
  initial forever begin
    @(negedge clk);
    if (violation) violCount++;
    if (rspValid) begin
      if (expRd.size() == 0) check(0, "R8", "unexpected read response", rspData, 32'h0);
      else begin
        automatic logic [31:0] e = expRd.pop_front();
        automatic string t = expRdTag.pop_front();
        check(rspData == e, t, "read data", rspData, e);
      end
    end
    if (memWrValid && memWrReady) begin
      memWrCount++;
      if (expWrAddr.size() == 0) check(0, "R4", "unexpected memory write", {16'h0, memWrAddr}, 32'h0);
      else begin
        automatic logic [15:0] ea = expWrAddr.pop_front();
        automatic logic [31:0] ed = expWrData.pop_front();
        check(memWrAddr == ea, "R10", "drain address", {16'h0, memWrAddr}, {16'h0, ea});
        check(memWrData == ed, "R10", "drain data", memWrData, ed);
      end
    end
  end

  task automatic issue(bit w, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic doRead(logic [15:0] a, logic [31:0] e, string tag);
    expRd.push_back(e);
    expRdTag.push_back(tag);
    issue(1'b0, a, 32'h0);
    while (expRd.size() != 0) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic startBlk();
    @(negedge clk); ctlStart = 1'b1;
    @(negedge clk); ctlStart = 1'b0;
  endtask

  task automatic abortBlk();
    @(negedge clk); ctlAbort = 1'b1;
    @(negedge clk); ctlAbort = 1'b0;
  endtask

  task automatic commitBlk(output int waited);
    @(negedge clk); ctlCommit = 1'b1; commitGrant = 1'b1;
    @(negedge clk); ctlCommit = 1'b0; commitGrant = 1'b0;
    waited = 0;
    do begin
      @(negedge clk);
      #1;
      waited++;
    end while (!commitDone && waited < 200);
  endtask

  task automatic snoop(logic [15:0] a);
    @(negedge clk); snoopValid = 1'b1; snoopAddr = a;
    @(negedge clk); snoopValid = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    check(0, "R1", "watchdog expired", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int rdBase;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle unit ignores requests
    check(!specActive && !rspValid && !memWrValid && !violation && !commitDone,
          "R1", "reset outputs", {27'h0, specActive, rspValid, memWrValid, violation, commitDone}, 32'h0);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0010;
    repeat (2) begin
      @(negedge clk);
      #1;
      check(!reqReady && !memRdReq, "R1", "idle request refused", {30'h0, reqReady, memRdReq}, 32'h0);
    end
    reqValid = 1'b0;

    // Main read/write path
    startBlk();
    check(specActive, "R1", "block opened", {31'h0, specActive}, 32'h1);
    doRead(16'h0010, memVal(16'h0010), "R2");
    check(memRdCount == 1, "R2", "miss reads memory", memRdCount, 1);
    doRead(16'h0010, memVal(16'h0010), "R3");
    check(memRdCount == 1, "R3", "dependency hit, no memory read", memRdCount, 1);
    doWrite(16'h0020, 32'h1111_1111);
    doRead(16'h0020, 32'h1111_1111, "R5");
    doWrite(16'h0010, 32'h2222_2222);
    doRead(16'h0010, 32'h2222_2222, "R5");
    check(memRdCount == 1, "R5", "buffer hit, no memory read", memRdCount, 1);
    doWrite(16'h0030, 32'h3333_3333);
    doWrite(16'h0020, 32'h4444_4444);
    doRead(16'h0020, 32'h4444_4444, "R5");
    // R7: harmless snoops
    snoop(16'h0020);
    snoop(16'h0099);
    @(negedge clk);
    check(violCount == 0 && specActive, "R7", "no violation, block open", violCount, 0);
    check(memWrCount == 0, "R4", "no write during block", memWrCount, 0);
    // R9: commit without grant
    @(negedge clk); ctlCommit = 1'b1;
    repeat (3) @(negedge clk);
    ctlCommit = 1'b0;
    check(!commitDone && specActive && !memWrValid, "R9", "commit held without grant",
          {30'h0, commitDone, memWrValid}, 32'h0);
    doRead(16'h0030, 32'h3333_3333, "R9");
    // R10/R12: three-entry commit
    expWrAddr.push_back(16'h0020); expWrData.push_back(32'h4444_4444);
    expWrAddr.push_back(16'h0010); expWrData.push_back(32'h2222_2222);
    expWrAddr.push_back(16'h0030); expWrData.push_back(32'h3333_3333);
    commitBlk(n);
    check(n == 4, "R12", "done timing with 3 entries", n, 4);
    check(expWrAddr.size() == 0, "R10", "all entries drained", expWrAddr.size(), 0);
    @(negedge clk);
    check(!commitDone && !specActive, "R12", "done is a pulse, unit idle", {30'h0, commitDone, specActive}, 32'h0);

    // R6: violation
    startBlk();
    doRead(16'h0040, memVal(16'h0040), "R2");
    doWrite(16'h0050, 32'h5555_5555);
    @(negedge clk); snoopValid = 1'b1; snoopAddr = 16'h0040;
    @(negedge clk); snoopValid = 1'b0;
    check(violation && !specActive, "R6", "violation and abort", {30'h0, violation, specActive}, 32'h2);
    @(negedge clk);
    check(!violation, "R6", "violation is one cycle", {31'h0, violation}, 32'h0);
    startBlk();
    rdBase = memRdCount;
    doRead(16'h0050, memVal(16'h0050), "R6");
    doRead(16'h0040, memVal(16'h0040), "R6");
    check(memRdCount == rdBase + 2, "R6", "state discarded after violation", memRdCount, rdBase + 2);
    commitBlk(n);
    check(n == 1, "R12", "done timing empty commit", n, 1);

    // R8: abort, including a read waiting on memory
    startBlk();
    doWrite(16'h0060, 32'h6666_6666);
    doRead(16'h0070, memVal(16'h0070), "R2");
    issue(1'b0, 16'h0080, 32'h0);
    abortBlk();
    repeat (5) @(negedge clk);
    check(!specActive && !rspValid, "R8", "abort drops pending read", {30'h0, specActive, rspValid}, 32'h0);
    startBlk();
    rdBase = memRdCount;
    doRead(16'h0060, memVal(16'h0060), "R8");
    doRead(16'h0070, memVal(16'h0070), "R8");
    check(memRdCount == rdBase + 2, "R8", "both structures cleared", memRdCount, rdBase + 2);
    commitBlk(n);
    check(n == 1 && memWrCount == 3, "R8", "nothing written back", memWrCount, 3);

    // R11: capacity stalls
    startBlk();
    for (int i = 0; i < 8; i++) doWrite(16'h0100 + 16'(i), 32'hA000_0000 + 32'(i));
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0108; reqWdata = 32'hDEAD_0000;
    repeat (3) begin
      @(negedge clk);
      #1;
      check(!reqReady, "R11", "write stalls when full", {31'h0, reqReady}, 32'h0);
    end
    reqValid = 1'b0;
    doWrite(16'h0103, 32'hBEEF_0003);
    for (int i = 0; i < 8; i++) doRead(16'h0200 + 16'(i), memVal(16'h0200 + 16'(i)), "R2");
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0208;
    repeat (3) begin
      @(negedge clk);
      #1;
      check(!reqReady && !memRdReq, "R11", "read stalls when full", {30'h0, reqReady, memRdReq}, 32'h0);
    end
    reqValid = 1'b0;
    rdBase = memRdCount;
    doRead(16'h0203, memVal(16'h0203), "R11");
    doRead(16'h0105, 32'hA000_0005, "R11");
    check(memRdCount == rdBase, "R11", "hits accepted while full", memRdCount, rdBase);
    // R10: drain under alternating backpressure
    for (int i = 0; i < 8; i++) begin
      expWrAddr.push_back(16'h0100 + 16'(i));
      expWrData.push_back(i == 3 ? 32'hBEEF_0003 : 32'hA000_0000 + 32'(i));
    end
    wrStall = 1'b1;
    commitBlk(n);
    wrStall = 1'b0;
    check(commitDone && expWrAddr.size() == 0, "R10", "drain under backpressure", expWrAddr.size(), 0);
    check(memWrCount == 11, "R10", "one write per entry", memWrCount, 11);
    check(violCount == 1, "R6", "single violation in run", violCount, 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule